// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a processor-side access port and a configuration request bus, and turns processor loads and stores into configuration cycles. It offers two routes. The first is an indirect pair in I/O space: a 32-bit address register that software loads first, then a four-byte data port whose byte, halfword and word accesses are forwarded with the register contents as the configuration address. The second is a direct window in memory space. There, a single address bit among bits 11 to 21 selects the device, and a priority encoder converts it into a binary device number.

Every access uses a level request from the processor side. The block raises a configuration request, waits for a one-cycle acknowledge, then acknowledges the processor. It holds the read data until the processor drops its request. When the host is big-endian, window data is byte-swapped in both directions. A small combinational router folds the per-slot interrupt pins onto two bus lines and drives two interrupt-controller inputs with them.

Top module: `cfg_xlate_top`

## Requirements
- R1: After reset, the address register reads as zero, `cfg_req` is low and `cpu_ack` is low.
- R2: An I/O-space word access (`cpu_size`=2) at address 0x0CF8 writes the address register or returns its last written value. A non-word access or an unaligned access in 0x0CF8..0x0CFB is ignored: the register is unchanged, a read returns 0xFFFFFFFF, and no configuration request is raised.
- R3: An I/O-space access at 0x0CFC..0x0CFF raises one configuration request. Its `cfg_addr` is the address register with bits [1:0] replaced by `cpu_addr[1:0]`. `cfg_size` equals `cpu_size` (0 byte, 1 halfword, 2 word). Data moves right-justified in both directions, is never swapped, and is masked to the access size.
- R4: A memory-space access raises a configuration request only when the address lies in 0x80800000..0x80BFFFFF. Any other access that is not covered by R2 or R3 raises no request and reads 0xFFFFFFFF.
- R5: For a window access, the device number is the index (0..10) of the lowest set bit among address bits 11..21; when several bits are set, the lowest one wins. `cfg_addr` is `cpu_addr[10:0]` with the device number placed at bit 11 and upward, and all other bits zero.
- R6: A window access with none of address bits 11..21 set uses device number 11.
- R7: With `BIG_ENDIAN`=1, window halfword data has its two bytes exchanged and window word data has its four bytes reversed, on both writes and reads. Byte accesses pass through unchanged. The upper bits of sub-word write data are driven as zero.
- R8: `cfg_req` stays high until a cycle in which `cfg_ack` is sampled high, drops on the next cycle, and is raised exactly once per forwarded access.
- R9: Once `cpu_ack` rises, it and `cpu_rdata` stay stable while `cpu_req` is held. `cpu_ack` falls on the clock edge after `cpu_req` is seen low.
- R10: Pin p (0..3) of slot s is routed to bus line (p + FIRST_DEV + s) mod 2. Line 0 drives `intc_in9` and line 1 drives `intc_in11`, each being the OR of its pin levels with no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_mem | input | 1 | 1 = memory space, 0 = I/O space |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_ack | output | 1 | Access done, held until `cpu_req` drops |
| cpu_rdata | output | 32 | Right-justified read data |
| cfg_req | output | 1 | Configuration request |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_size | output | 2 | Configuration access size |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | One-cycle completion from the configuration bus |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_ack` |
| slot_irq | input | N_SLOT*4 | Interrupt pin levels, bit s*4+p is pin p of slot s |
| intc_in9 | output | 1 | Interrupt controller input for bus line 0 |
| intc_in11 | output | 1 | Interrupt controller input for bus line 1 |

## Verification
The embedded properties watch the two handshakes on every cycle. They check that the configuration request is held until its acknowledge and drops right after it, that the processor acknowledge and its data stay put while the request is held, and that no configuration request is ever open while the processor is acknowledged. They also check that the device-number encoder never yields the reserved value for a non-empty select field, and that idle interrupt pins leave both controller inputs low. The numeric mapping cannot be checked that way and is shown only by the directed scenarios: the lowest-set-bit priority, the no-bit case, the window limits, the byte-lane swaps, register read-back and the interrupt line choice.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } xl_state_e;

    typedef enum logic [1:0] {
        ACC_AREG = 2'd0,
        ACC_DATA = 2'd1,
        ACC_WIN  = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        xl_state_e   state;
        logic [31:0] areg;
        logic        cfg_req;
        logic        cfg_we;
        logic [31:0] cfg_addr;
        logic [1:0]  cfg_size;
        logic [31:0] cfg_wdata;
        logic        win;
        logic        ack;
        logic [31:0] rdata;
    } xl_regs_t;

    function automatic logic [31:0] size_mask(input logic [1:0] sz, input logic [31:0] v);
        logic [31:0] r;
        case (sz)
            SZ_BYTE: r = {24'd0, v[7:0]};
            SZ_HALF: r = {16'd0, v[15:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
    parameter int SEL_LSB  = 11,
    parameter int SEL_BITS = 11,
    parameter int DEV_W    = $clog2(SEL_BITS + 1),
    parameter int LOW_W    = SEL_LSB + SEL_BITS
) (
    input  logic [LOW_W-1:0] win_addr,
    output logic [DEV_W-1:0] dev_num,
    output logic [31:0]      xl_addr
);
    logic [SEL_BITS-1:0] sel;
    logic [SEL_BITS:0]   seen;
    logic [SEL_BITS-1:0] first;

    assign sel = win_addr[LOW_W-1:SEL_LSB];

    // Priority chain, lowest index first.
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < SEL_BITS; i++) begin : g_chain
        assign first[i]    = sel[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | sel[i];
    end

    always_comb begin
        dev_num = DEV_W'(SEL_BITS);
        for (int i = 0; i < SEL_BITS; i++) begin
            if (first[i]) dev_num = DEV_W'(i);
        end
    end

    always_comb begin
        xl_addr = 32'd0;
        xl_addr[SEL_LSB-1:0] = win_addr[SEL_LSB-1:0];
        xl_addr = xl_addr | (32'(dev_num) << SEL_LSB);
    end

    // R6: the reserved device number appears exactly when no select bit is set
    always_comb begin
        a_r6_none_maps_last: assert ((sel == '0) == (dev_num == DEV_W'(SEL_BITS)));
        a_r5_single_winner:  assert ($onehot0(first));
    end

endmodule

// File: rtl/cfg_lane_swap.sv
module cfg_lane_swap #(
    parameter bit SWAP_EN = 1'b1
) (
    input  logic [1:0]  size,
    input  logic [31:0] din,
    output logic [31:0] dout
);
    import cfg_xlate_pkg::*;

    logic [31:0] masked;
    assign masked = size_mask(size, din);

    if (SWAP_EN) begin : g_swap
        always_comb begin
            case (size)
                SZ_BYTE: dout = masked;
                SZ_HALF: dout = {16'd0, masked[7:0], masked[15:8]};
                default: dout = {masked[7:0], masked[15:8], masked[23:16], masked[31:24]};
            endcase
        end
    end else begin : g_pass
        assign dout = masked;
    end

endmodule

// File: rtl/cfg_irq_route.sv
module cfg_irq_route #(
    parameter int N_SLOT    = 4,
    parameter int N_PIN     = 4,
    parameter int FIRST_DEV = 1
) (
    input  logic [N_SLOT*N_PIN-1:0] slot_irq,
    output logic                    line0,
    output logic                    line1
);
    logic [N_SLOT*N_PIN-1:0] on_line1;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        for (genvar p = 0; p < N_PIN; p++) begin : g_pin
            localparam bit LINE = ((p + FIRST_DEV + s) % 2) == 1;
            assign on_line1[s*N_PIN + p] = LINE;
        end
    end

    assign line0 = |(slot_irq & ~on_line1);
    assign line1 = |(slot_irq & on_line1);

    // R10: no active pin means both lines idle
    always_comb begin
        a_r10_idle_lines: assert ((slot_irq != '0) || (!line0 && !line1));
    end

endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
    import cfg_xlate_pkg::*;
#(
    parameter logic [31:0] AREG_PORT  = 32'h0000_0CF8,
    parameter logic [31:0] DATA_PORT  = 32'h0000_0CFC,
    parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
    parameter logic [31:0] WIN_SPAN   = 32'h0040_0000,
    parameter int          SEL_LSB    = 11,
    parameter int          SEL_BITS   = 11,
    parameter bit          BIG_ENDIAN = 1'b1,
    parameter int          N_SLOT     = 4,
    parameter int          FIRST_DEV  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic                  cpu_mem,
    input  logic [31:0]           cpu_addr,
    input  logic [1:0]            cpu_size,
    input  logic [31:0]           cpu_wdata,
    output logic                  cpu_ack,
    output logic [31:0]           cpu_rdata,
    output logic                  cfg_req,
    output logic                  cfg_we,
    output logic [31:0]           cfg_addr,
    output logic [1:0]            cfg_size,
    output logic [31:0]           cfg_wdata,
    input  logic                  cfg_ack,
    input  logic [31:0]           cfg_rdata,
    input  logic [N_SLOT*4-1:0]   slot_irq,
    output logic                  intc_in9,
    output logic                  intc_in11
);
    localparam int          LOW_W   = SEL_LSB + SEL_BITS;
    localparam int          DEV_W   = $clog2(SEL_BITS + 1);
    localparam logic [32:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_SPAN};
    localparam logic [31:0] ALL_ONE = '1;

    xl_regs_t q, d;

    // ---------------- address classification ----------------
    logic      hit_areg_q, hit_data, hit_win;
    acc_kind_e kind;

    assign hit_areg_q = !cpu_mem && (cpu_addr[31:2] == AREG_PORT[31:2]);
    assign hit_data   = !cpu_mem && (cpu_addr[31:2] == DATA_PORT[31:2]);
    assign hit_win    = cpu_mem && (cpu_addr >= WIN_BASE) && ({1'b0, cpu_addr} < WIN_END);

    always_comb begin
        if (hit_areg_q)
            kind = (cpu_size == 2'd2 && cpu_addr[1:0] == 2'b00) ? ACC_AREG : ACC_NONE;
        else if (hit_data)
            kind = ACC_DATA;
        else if (hit_win)
            kind = ACC_WIN;
        else
            kind = ACC_NONE;
    end

    // ---------------- window translation and lanes ----------------
    logic [DEV_W-1:0] win_dev;
    logic [31:0]      win_addr_xl;
    logic [31:0]      wr_swapped, rd_swapped;
    logic [31:0]      wr_plain, rd_plain;

    cfg_win_decode #(
        .SEL_LSB (SEL_LSB),
        .SEL_BITS(SEL_BITS),
        .DEV_W   (DEV_W),
        .LOW_W   (LOW_W)
    ) u_dec (
        .win_addr(cpu_addr[LOW_W-1:0]),
        .dev_num (win_dev),
        .xl_addr (win_addr_xl)
    );

    cfg_lane_swap #(.SWAP_EN(BIG_ENDIAN)) u_wr_swap (
        .size(cpu_size),
        .din (cpu_wdata),
        .dout(wr_swapped)
    );

    cfg_lane_swap #(.SWAP_EN(BIG_ENDIAN)) u_rd_swap (
        .size(q.cfg_size),
        .din (cfg_rdata),
        .dout(rd_swapped)
    );

    assign wr_plain = size_mask(cpu_size, cpu_wdata);
    assign rd_plain = size_mask(q.cfg_size, cfg_rdata);

    // ---------------- next-state logic ----------------
    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    case (kind)
                        ACC_AREG: begin
                            if (cpu_we) d.areg = cpu_wdata;
                            d.rdata = q.areg;
                            d.ack   = 1'b1;
                            d.state = ST_DONE;
                        end
                        ACC_DATA: begin
                            d.cfg_req   = 1'b1;
                            d.cfg_we    = cpu_we;
                            d.cfg_addr  = {q.areg[31:2], cpu_addr[1:0]};
                            d.cfg_size  = cpu_size;
                            d.cfg_wdata = wr_plain;
                            d.win       = 1'b0;
                            d.state     = ST_BUS;
                        end
                        ACC_WIN: begin
                            d.cfg_req   = 1'b1;
                            d.cfg_we    = cpu_we;
                            d.cfg_addr  = win_addr_xl;
                            d.cfg_size  = cpu_size;
                            d.cfg_wdata = wr_swapped;
                            d.win       = 1'b1;
                            d.state     = ST_BUS;
                        end
                        default: begin
                            d.rdata = ALL_ONE;
                            d.ack   = 1'b1;
                            d.state = ST_DONE;
                        end
                    endcase
                end
            end
            ST_BUS: begin
                if (cfg_ack) begin
                    d.cfg_req = 1'b0;
                    d.rdata   = q.win ? rd_swapped : rd_plain;
                    d.ack     = 1'b1;
                    d.state   = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!cpu_req) begin
                    d.ack   = 1'b0;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.areg      <= '0;
            q.cfg_req   <= 1'b0;
            q.cfg_we    <= 1'b0;
            q.cfg_addr  <= '0;
            q.cfg_size  <= '0;
            q.cfg_wdata <= '0;
            q.win       <= 1'b0;
            q.ack       <= 1'b0;
            q.rdata     <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_ack   = q.ack;
    assign cpu_rdata = q.rdata;
    assign cfg_req   = q.cfg_req;
    assign cfg_we    = q.cfg_we;
    assign cfg_addr  = q.cfg_addr;
    assign cfg_size  = q.cfg_size;
    assign cfg_wdata = q.cfg_wdata;

    // ---------------- interrupt routing ----------------
    cfg_irq_route #(
        .N_SLOT   (N_SLOT),
        .N_PIN    (4),
        .FIRST_DEV(FIRST_DEV)
    ) u_irq (
        .slot_irq(slot_irq),
        .line0   (intc_in9),
        .line1   (intc_in11)
    );

    // ---------------- properties ----------------
    // R8: request held until acknowledged
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req);

    // R8: request released right after acknowledge
    a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_ack |=> !cfg_req && cpu_ack);

    // R9: acknowledge and data stable while processor holds its request
    a_r9_ack_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && cpu_req |=> cpu_ack && $stable(cpu_rdata));

    // R9: acknowledge released after the request drops
    a_r9_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && !cpu_req |=> !cpu_ack);

    // R8: no configuration request is open while the processor is acknowledged
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && cpu_ack));

endmodule

// File: tb/tb_cfg_xlate_top.sv
module tb_cfg_xlate_top;

    localparam int N_SLOT = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cpu_req = 1'b0, cpu_we = 1'b0, cpu_mem = 1'b0;
    logic [31:0]          cpu_addr = '0, cpu_wdata = '0;
    logic [1:0]           cpu_size = '0;
    logic                 cpu_ack;
    logic [31:0]          cpu_rdata;
    logic                 cfg_req, cfg_we;
    logic [31:0]          cfg_addr, cfg_wdata;
    logic [1:0]           cfg_size;
    logic                 cfg_ack = 1'b0;
    logic [31:0]          cfg_rdata = '0;
    logic [N_SLOT*4-1:0]  slot_irq = '0;
    logic                 intc_in9, intc_in11;

    int errors = 0;
    int checks = 0;

    // bus model bookkeeping
    int          bus_lat = 1;
    int          bus_cnt = 0;
    int          nreq = 0;
    logic        seen_we;
    logic [31:0] seen_addr, seen_wdata;
    logic [1:0]  seen_size;

    always #2 clk = ~clk;

    cfg_xlate_top dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_mem(cpu_mem),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .slot_irq(slot_irq), .intc_in9(intc_in9), .intc_in11(intc_in11)
    );

    // Configuration bus responder: acks after bus_lat cycles of request.
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_ack) begin
                cfg_ack = 1'b0;
                bus_cnt = 0;
            end else if (cfg_req) begin
                bus_cnt++;
                if (bus_cnt >= bus_lat) begin
                    seen_we    = cfg_we;
                    seen_addr  = cfg_addr;
                    seen_wdata = cfg_wdata;
                    seen_size  = cfg_size;
                    case (cfg_size)
                        2'd0:    cfg_rdata = 32'h0000_0077;
                        2'd1:    cfg_rdata = 32'h0000_5566;
                        default: cfg_rdata = 32'h1122_3344;
                    endcase
                    cfg_ack = 1'b1;
                    nreq++;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One processor access; checks hold and release behaviour (R9) each time.
    task automatic access(input logic mem, input logic we, input logic [31:0] addr,
                          input logic [1:0] sz, input logic [31:0] wd,
                          output logic [31:0] rd, output int reqs);
        int start = nreq;
        @(negedge clk);
        cpu_mem = mem; cpu_we = we; cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
        cpu_req = 1'b1;
        for (int i = 0; i < 50 && !cpu_ack; i++) @(negedge clk);
        rd = cpu_rdata;
        repeat (2) @(negedge clk);
        check("R9 ack held", {31'd0, cpu_ack}, 32'd1);
        check("R9 rdata held", cpu_rdata, rd);
        cpu_req = 1'b0;
        @(negedge clk);
        check("R9 ack released", {31'd0, cpu_ack}, 32'd0);
        reqs = nreq - start;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int n;
        check("R1 cfg_req after reset", {31'd0, cfg_req}, 32'd0);
        check("R1 cpu_ack after reset", {31'd0, cpu_ack}, 32'd0);
        access(1'b0, 1'b0, 32'h0CF8, 2'd2, 0, rd, n);
        check("R1 address register zero", rd, 32'h0);
    endtask

    task automatic t_areg();
        logic [31:0] rd; int n;
        access(1'b0, 1'b1, 32'h0CF8, 2'd2, 32'h8000_1234, rd, n);
        check("R2 areg write no request", n, 0);
        access(1'b0, 1'b0, 32'h0CF8, 2'd2, 0, rd, n);
        check("R2 areg readback", rd, 32'h8000_1234);
        access(1'b0, 1'b1, 32'h0CF9, 2'd0, 32'h55, rd, n);
        check("R2 byte write no request", n, 0);
        access(1'b0, 1'b0, 32'h0CFA, 2'd1, 0, rd, n);
        check("R2 half read all ones", rd, 32'hFFFF_FFFF);
        access(1'b0, 1'b0, 32'h0CF8, 2'd2, 0, rd, n);
        check("R2 areg unchanged", rd, 32'h8000_1234);
    endtask

    task automatic t_data_port();
        logic [31:0] rd; int n;
        bus_lat = 3;
        access(1'b0, 1'b1, 32'h0CFE, 2'd1, 32'hABCD_1234, rd, n);
        check("R8 one request", n, 1);
        check("R3 data addr", seen_addr, 32'h8000_1236);
        check("R3 data size", {30'd0, seen_size}, 32'd1);
        check("R3 data wdata unswapped", seen_wdata, 32'h0000_1234);
        check("R3 data we", {31'd0, seen_we}, 32'd1);
        access(1'b0, 1'b0, 32'h0CFC, 2'd2, 0, rd, n);
        check("R3 data word read", rd, 32'h1122_3344);
        check("R3 word addr", seen_addr, 32'h8000_1234);
        access(1'b0, 1'b0, 32'h0CFF, 2'd0, 0, rd, n);
        check("R3 byte read", rd, 32'h0000_0077);
        bus_lat = 1;
    endtask

    task automatic t_window_decode();
        logic [31:0] rd; int n;
        access(1'b1, 1'b0, 32'h8080_0000 | (32'h1 << 14) | 32'h2A4, 2'd2, 0, rd, n);
        check("R5 dev 3 addr", seen_addr, 32'h0000_1AA4);
        access(1'b1, 1'b0, 32'h8080_0000 | (32'h1 << 13) | (32'h1 << 19) | 32'h10, 2'd2, 0, rd, n);
        check("R5 lowest bit wins", seen_addr, 32'h0000_1010);
        access(1'b1, 1'b0, 32'h80A0_0010, 2'd2, 0, rd, n);
        check("R5 top select bit", seen_addr, 32'h0000_5010);
        access(1'b1, 1'b0, 32'h8080_07FC, 2'd2, 0, rd, n);
        check("R6 no bit set", seen_addr, 32'h0000_5FFC);
        check("R6 request raised", n, 1);
    endtask

    task automatic t_window_range();
        logic [31:0] rd; int n;
        access(1'b1, 1'b0, 32'h80BF_FFFC, 2'd2, 0, rd, n);
        check("R4 last window word forwarded", n, 1);
        access(1'b1, 1'b0, 32'h80C0_0000, 2'd2, 0, rd, n);
        check("R4 above window no request", n, 0);
        check("R4 above window reads ones", rd, 32'hFFFF_FFFF);
        access(1'b1, 1'b1, 32'h807F_FFFC, 2'd2, 32'h1, rd, n);
        check("R4 below window no request", n, 0);
        access(1'b0, 1'b0, 32'h0CF4, 2'd2, 0, rd, n);
        check("R4 other io reads ones", rd, 32'hFFFF_FFFF);
    endtask

    task automatic t_swap();
        logic [31:0] rd; int n;
        access(1'b1, 1'b1, 32'h8080_0800, 2'd2, 32'hAABB_CCDD, rd, n);
        check("R7 word write swapped", seen_wdata, 32'hDDCC_BBAA);
        access(1'b1, 1'b1, 32'h8080_0802, 2'd1, 32'hFFFF_1234, rd, n);
        check("R7 half write swapped", seen_wdata, 32'h0000_3412);
        access(1'b1, 1'b1, 32'h8080_0803, 2'd0, 32'h0000_005A, rd, n);
        check("R7 byte write unchanged", seen_wdata, 32'h0000_005A);
        access(1'b1, 1'b0, 32'h8080_0800, 2'd2, 0, rd, n);
        check("R7 word read swapped", rd, 32'h4433_2211);
        access(1'b1, 1'b0, 32'h8080_0802, 2'd1, 0, rd, n);
        check("R7 half read swapped", rd, 32'h0000_6655);
        access(1'b1, 1'b0, 32'h8080_0801, 2'd0, 0, rd, n);
        check("R7 byte read unchanged", rd, 32'h0000_0077);
    endtask

    task automatic t_irq();
        // FIRST_DEV = 1: slot s pin p goes to line (p + 1 + s) mod 2
        slot_irq = '0;
        #1;
        check("R10 idle line0", {31'd0, intc_in9}, 32'd0);
        check("R10 idle line1", {31'd0, intc_in11}, 32'd0);
        slot_irq = 16'h0001;  // slot0 pin0 -> line 1
        #1;
        check("R10 s0p0 to in11", {30'd0, intc_in11, intc_in9}, 32'd2);
        slot_irq = 16'h0002;  // slot0 pin1 -> line 0
        #1;
        check("R10 s0p1 to in9", {30'd0, intc_in11, intc_in9}, 32'd1);
        slot_irq = 16'h0010;  // slot1 pin0 -> line 0
        #1;
        check("R10 s1p0 to in9", {30'd0, intc_in11, intc_in9}, 32'd1);
        slot_irq = 16'h8000;  // slot3 pin3 -> line 1
        #1;
        check("R10 s3p3 to in11", {30'd0, intc_in11, intc_in9}, 32'd2);
        slot_irq = '0;
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_run();
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_areg();
        t_data_port();
        t_window_decode();
        t_window_range();
        t_swap();
        t_irq();
        finish_run();
    end

endmodule